// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer for UV-Erasable Memory

This block runs one access to an ultraviolet-erasable byte memory through discrete, active-low control strobes. The address is prepared elsewhere before the request is raised. A request carries a direction flag and a data byte. For a program request the block lowers nothing until output-enable is confirmed high. It then raises a request for the high programming voltage, drives the data, selects the chip and holds the program strobe low for a long timed pulse. After the pulse it releases the data bus and reads the location back through output-enable. Finally it drops the strobes in reverse order.

The stored byte after a program pulse is the old contents ANDed with the written byte, because programming only clears bits. An erased location reads 0xFF. The verify step therefore fails whenever the written byte asks for a 1 where the cell already holds a 0. A read request runs a short cycle on the same strobes and returns the sampled byte. Every cycle ends with a one-cycle done indication and a fail flag.

Top module: `eprom_byte_prog`

## Requirements
- R1: After reset cs_n_o, oe_n_o and pgm_n_o are high, vpp_req_o, mem_d_oe_o, busy_o and done_o are low.
- R2: In a program cycle the output transitions occur in this order: vpp_req_o rises, then mem_d_oe_o rises, then cs_n_o falls, then pgm_n_o falls. While pgm_n_o is low, cs_n_o is low, oe_n_o is high, vpp_req_o is high and mem_d_oe_o is high.
- R3: pgm_n_o stays low for exactly PULSE_CYCLES clock cycles per program cycle.
- R4: mem_d_oe_o is never high while oe_n_o is low. mem_d_oe_o is high only while vpp_req_o is high.
- R5: After the pulse, the transitions occur in this order: mem_d_oe_o falls, oe_n_o falls, oe_n_o rises, cs_n_o rises, vpp_req_o falls. When vpp_req_o falls, cs_n_o and oe_n_o are already high.
- R6: At the end of a program cycle, fail_o is 1 exactly when the read-back byte differs from wdata_i. fail_o is presented with done_o and held until the next accepted request. All strobes are inactive while done_o is high.
- R7: rdata_o returns the byte sampled from mem_d_i. For a program over existing contents this is old AND new; for example, 0x03 written over 0x81 yields 0x01 and fail_o = 1.
- R8: A read cycle (write_i = 0) lowers oe_n_o before cs_n_o, samples, then raises cs_n_o before oe_n_o. It never lowers pgm_n_o, never raises vpp_req_o or mem_d_oe_o, and it reports fail_o = 0.
- R9: start_i is ignored while busy_o is high. The running cycle and its data are unaffected, and no further cycle follows.
- R10: done_o is high for exactly one cycle. busy_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| write_i | input | 1 | 1 = program and verify, 0 = read |
| wdata_i | input | DATA_W | Byte to program |
| mem_d_i | input | DATA_W | Data bus as seen from the memory |
| mem_d_o | output | DATA_W | Data driven onto the bus |
| mem_d_oe_o | output | 1 | Bus drive enable (1 = block drives) |
| cs_n_o | output | 1 | Chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| pgm_n_o | output | 1 | Program strobe, active low |
| vpp_req_o | output | 1 | Request for the high programming voltage |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle end-of-cycle indication |
| fail_o | output | 1 | Verify mismatch, valid with done_o |
| rdata_o | output | DATA_W | Sampled byte |

## Verification
The hardest cases to reach are a verify failure caused by earlier contents and a request that arrives in the middle of a running cycle. A random failure needs a location already programmed with zeros that a later byte tries to set back to one. The bench therefore works on a small set of addresses, so random programs land on used cells. It also mixes in directed cases: 0x03 over 0x81, a rewrite of a byte that is already present, and a second request raised during the program pulse. The second request carries different data, and its absence is shown by the unchanged read-back byte and by busy_o staying low afterwards.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

   typedef enum logic [4:0] {
      ST_IDLE,
      W_OE_OFF,
      W_VPP_ON,
      W_DRIVE,
      W_CS_ON,
      W_PULSE,
      W_PULSE_END,
      W_TURN,
      W_OE_ON,
      W_SAMPLE,
      W_OE_REL,
      W_CS_REL,
      W_VPP_OFF,
      R_OE_ON,
      R_CS_ON,
      R_SAMPLE,
      R_CS_REL,
      R_OE_REL,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic oe_n;
      logic pgm_n;
      logic vpp;
      logic bus_oe;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1,
                                       vpp: 1'b0, bus_oe: 1'b0};

   // successor of a timed state
   function automatic seq_state_e step_after(input seq_state_e s);
      case (s)
         W_OE_OFF:    return W_VPP_ON;
         W_VPP_ON:    return W_DRIVE;
         W_DRIVE:     return W_CS_ON;
         W_CS_ON:     return W_PULSE;
         W_PULSE:     return W_PULSE_END;
         W_PULSE_END: return W_TURN;
         W_TURN:      return W_OE_ON;
         W_OE_ON:     return W_SAMPLE;
         W_SAMPLE:    return W_OE_REL;
         W_OE_REL:    return W_CS_REL;
         W_CS_REL:    return W_VPP_OFF;
         W_VPP_OFF:   return ST_DONE;
         R_OE_ON:     return R_CS_ON;
         R_CS_ON:     return R_SAMPLE;
         R_SAMPLE:    return R_CS_REL;
         R_CS_REL:    return R_OE_REL;
         R_OE_REL:    return ST_DONE;
         default:     return ST_IDLE;
      endcase
   endfunction

   // strobe levels held during each state
   function automatic strobe_t levels_of(input seq_state_e s);
      strobe_t l;
      l = STROBE_IDLE;
      case (s)
         W_VPP_ON:    l.vpp = 1'b1;
         W_DRIVE:     begin l.vpp = 1'b1; l.bus_oe = 1'b1; end
         W_CS_ON,
         W_PULSE_END: begin l.vpp = 1'b1; l.bus_oe = 1'b1; l.cs_n = 1'b0; end
         W_PULSE:     begin l.vpp = 1'b1; l.bus_oe = 1'b1; l.cs_n = 1'b0;
                            l.pgm_n = 1'b0; end
         W_TURN:      begin l.vpp = 1'b1; l.cs_n = 1'b0; end
         W_OE_ON,
         W_SAMPLE:    begin l.vpp = 1'b1; l.cs_n = 1'b0; l.oe_n = 1'b0; end
         W_OE_REL:    begin l.vpp = 1'b1; l.cs_n = 1'b0; end
         W_CS_REL:    l.vpp = 1'b1;
         R_OE_ON,
         R_CS_REL:    l.oe_n = 1'b0;
         R_CS_ON,
         R_SAMPLE:    begin l.oe_n = 1'b0; l.cs_n = 1'b0; end
         default:     l = STROBE_IDLE;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
   parameter int unsigned PULSE_CYCLES = 2_500_000,
   parameter int unsigned STEP_CYCLES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic long_i,
   output logic expired_o
);
   localparam int unsigned MAX_C = (PULSE_CYCLES > STEP_CYCLES) ? PULSE_CYCLES : STEP_CYCLES;
   localparam int unsigned CNT_W = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(PULSE_CYCLES - 1);
   localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(STEP_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= long_i ? LONG_LD : SHORT_LD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

   p_load_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && long_i |=> cnt_q == LONG_LD);

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
   import eprom_prog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e nxt_i,
   output strobe_t    strb_o
);
   strobe_t strb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         strb_q <= STROBE_IDLE;
      else
         strb_q <= levels_of(nxt_i);
   end

   assign strb_o = strb_q;

   p_vpp_with_pgm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_q.pgm_n |-> strb_q.vpp);

endmodule

// File: rtl/readback_check.sv
module readback_check #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          VERIFY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              capture_i,
   input  logic              check_i,
   input  logic [DATA_W-1:0] bus_i,
   input  logic [DATA_W-1:0] ref_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              fail_o
);
   logic [DATA_W-1:0] diff;
   logic              mism;
   logic [DATA_W-1:0] rdata_q;
   logic              fail_q;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign diff[b] = bus_i[b] ^ ref_i[b];
   end

   if (VERIFY_EN) begin : g_verify
      assign mism = check_i && (|diff);
   end else begin : g_noverify
      assign mism = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         fail_q  <= 1'b0;
      end else if (clear_i) begin
         fail_q  <= 1'b0;
      end else if (capture_i) begin
         rdata_q <= bus_i;
         fail_q  <= mism;
      end
   end

   assign rdata_o = rdata_q;
   assign fail_o  = fail_q;

   p_read_no_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i && !check_i |=> !fail_q);

endmodule

// File: rtl/eprom_byte_prog.sv
module eprom_byte_prog
   import eprom_prog_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PULSE_CYCLES = 2_500_000,
   parameter int unsigned STEP_CYCLES  = 2,
   parameter bit          VERIFY_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              write_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] mem_d_i,
   output logic [DATA_W-1:0] mem_d_o,
   output logic              mem_d_oe_o,
   output logic              cs_n_o,
   output logic              oe_n_o,
   output logic              pgm_n_o,
   output logic              vpp_req_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned PL_W = $clog2(PULSE_CYCLES + 2);

   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be at least 1");
   end
   if (PULSE_CYCLES < 1) begin : g_bad_p
      $error("PULSE_CYCLES must be at least 1");
   end
   if (STEP_CYCLES < 1) begin : g_bad_s
      $error("STEP_CYCLES must be at least 1");
   end

   seq_state_e        state_q, state_d;
   logic              load, long_ld, expired, accept, capture;
   logic              mode_wr_q;
   logic [DATA_W-1:0] data_q;
   strobe_t           strb;

   assign accept = (state_q == ST_IDLE) && start_i;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      case (state_q)
         ST_IDLE: if (start_i) begin
            state_d = write_i ? W_OE_OFF : R_OE_ON;
            load    = 1'b1;
         end
         ST_DONE: state_d = ST_IDLE;
         default: if (expired) begin
            state_d = step_after(state_q);
            load    = 1'b1;
         end
      endcase
      long_ld = (state_d == W_PULSE);
   end

   assign capture = expired && ((state_q == W_SAMPLE) || (state_q == R_SAMPLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mode_wr_q <= 1'b0;
         data_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            mode_wr_q <= write_i;
            data_q    <= wdata_i;
         end
      end
   end

   step_timer #(
      .PULSE_CYCLES(PULSE_CYCLES),
      .STEP_CYCLES (STEP_CYCLES)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .long_i   (long_ld),
      .expired_o(expired)
   );

   strobe_decode i_strobes (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt_i (state_d),
      .strb_o(strb)
   );

   readback_check #(
      .DATA_W   (DATA_W),
      .VERIFY_EN(VERIFY_EN)
   ) i_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (accept),
      .capture_i(capture),
      .check_i  (mode_wr_q),
      .bus_i    (mem_d_i),
      .ref_i    (data_q),
      .rdata_o  (rdata_o),
      .fail_o   (fail_o)
   );

   assign mem_d_o    = data_q;
   assign mem_d_oe_o = strb.bus_oe;
   assign cs_n_o     = strb.cs_n;
   assign oe_n_o     = strb.oe_n;
   assign pgm_n_o    = strb.pgm_n;
   assign vpp_req_o  = strb.vpp;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = (state_q == ST_DONE);

   // pulse width monitor for the program strobe
   logic [PL_W-1:0] pulse_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pulse_len_q <= '0;
      else if (!pgm_n_o)
         pulse_len_q <= pulse_len_q + 1'b1;
      else
         pulse_len_q <= '0;
   end

   p_pgm_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pgm_n_o |-> (!cs_n_o && oe_n_o && vpp_req_o && mem_d_oe_o));

   p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgm_n_o) |-> (pulse_len_q == PL_W'(PULSE_CYCLES)));

   p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_o |-> !mem_d_oe_o);

   p_drive_needs_vpp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_d_oe_o |-> vpp_req_o);

   p_vpp_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vpp_req_o) |-> (cs_n_o && oe_n_o));

   p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && oe_n_o && pgm_n_o && !vpp_req_o && !mem_d_oe_o));

   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(mem_d_o));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/test_eprom_byte_prog.sv
module test_eprom_byte_prog;
   localparam int unsigned DW    = 8;
   localparam int unsigned PULSE = 40;
   localparam int unsigned STEP  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] bus_in, bus_out, rdata;
   logic          bus_oe, cs_n, oe_n, pgm_n, vpp, busy, done, fail;

   int nchk = 0;
   int nfail = 0;

   logic [DW-1:0] mem [16];
   logic [DW-1:0] shadow [16];
   logic [3:0]    addr = '0;

   always #10 clk = ~clk;

   eprom_byte_prog #(.DATA_W(DW), .PULSE_CYCLES(PULSE), .STEP_CYCLES(STEP)) i_eprom_byte_prog (
      .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr), .wdata_i(wdata),
      .mem_d_i(bus_in), .mem_d_o(bus_out), .mem_d_oe_o(bus_oe), .cs_n_o(cs_n),
      .oe_n_o(oe_n), .pgm_n_o(pgm_n), .vpp_req_o(vpp), .busy_o(busy),
      .done_o(done), .fail_o(fail), .rdata_o(rdata));

   // memory model: drives only when selected and enabled
   assign bus_in = (!cs_n && !oe_n && !bus_oe) ? mem[addr] : '0;

   always @(posedge pgm_n)
      if (cs_n === 1'b0 && vpp === 1'b1)
         mem[addr] <= mem[addr] & bus_out;

   // monitor: transition times, pulse width, contention
   int cyc = 0;
   int t_vpp_up, t_vpp_dn, t_boe_up, t_boe_dn, t_cs_dn, t_cs_up;
   int t_pgm_dn, t_pgm_up, t_oe_dn, t_oe_up;
   int pcnt = 0, last_pulse = 0, npulse = 0, contention = 0;
   logic p_vpp = 0, p_boe = 0, p_cs = 1, p_oe = 1, p_pgm = 1;

   always @(negedge clk) begin
      cyc++;
      if (vpp && !p_vpp) t_vpp_up = cyc;
      if (!vpp && p_vpp) t_vpp_dn = cyc;
      if (bus_oe && !p_boe) t_boe_up = cyc;
      if (!bus_oe && p_boe) t_boe_dn = cyc;
      if (!cs_n && p_cs) t_cs_dn = cyc;
      if (cs_n && !p_cs) t_cs_up = cyc;
      if (!oe_n && p_oe) t_oe_dn = cyc;
      if (oe_n && !p_oe) t_oe_up = cyc;
      if (!pgm_n && p_pgm) begin t_pgm_dn = cyc; npulse++; end
      if (pgm_n && !p_pgm) t_pgm_up = cyc;
      if (!pgm_n) pcnt++;
      else if (pcnt != 0) begin last_pulse = pcnt; pcnt = 0; end
      if (rst_n && !oe_n && bus_oe) contention++;
      p_vpp = vpp; p_boe = bus_oe; p_cs = cs_n; p_oe = oe_n; p_pgm = pgm_n;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] after_prog(input logic [DW-1:0] old, input logic [DW-1:0] nw);
      return old & nw;
   endfunction

   task automatic wait_done(output logic [DW-1:0] rd, output logic f);
      do @(negedge clk); while (!done);
      rd = rdata;
      f  = fail;
      check("R6 strobes idle at done", {27'd0, cs_n, oe_n, pgm_n, vpp, bus_oe}, 32'h1C);
      @(negedge clk);
      check("R10 done single cycle", {30'd0, done, busy}, 32'd0);
   endtask

   task automatic run_op(input logic w, input logic [3:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] rd, exp_rd;
      logic          f, exp_f;
      int            np0;
      int            cont0;
      np0   = npulse;
      cont0 = contention;
      addr  = a;
      @(negedge clk);
      start = 1'b1; wr = w; wdata = d;
      @(negedge clk);
      start = 1'b0;
      wait_done(rd, f);
      if (w) begin
         exp_rd = after_prog(shadow[a], d);
         exp_f  = (exp_rd != d);
         shadow[a] = exp_rd;
         check("R3 pulse width", last_pulse, PULSE);
         check("R2 order", {28'd0, t_vpp_up < t_boe_up, t_boe_up < t_cs_dn,
                            t_cs_dn < t_pgm_dn, t_pgm_dn < t_pgm_up}, 32'hF);
         check("R5 order", {27'd0, t_pgm_up < t_boe_dn, t_boe_dn < t_oe_dn,
                            t_oe_dn < t_oe_up, t_oe_up < t_cs_up, t_cs_up < t_vpp_dn}, 32'h1F);
      end else begin
         exp_rd = shadow[a];
         exp_f  = 1'b0;
         check("R8 no pulse in read", npulse - np0, 0);
         check("R8 order", {29'd0, t_oe_dn < t_cs_dn, t_cs_dn < t_cs_up,
                            t_cs_up < t_oe_up}, 32'h7);
      end
      check("R4 no contention", contention - cont0, 0);
      check("R7 read-back byte", rdata, exp_rd);
      check("R6 verify flag", f, exp_f);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      logic          f;
      void'($urandom(32'd4242));
      for (int i = 0; i < 16; i++) begin mem[i] = 8'hFF; shadow[i] = 8'hFF; end
      repeat (3) @(negedge clk);
      check("R1 reset strobes", {27'd0, cs_n, oe_n, pgm_n, vpp, bus_oe}, 32'h1C);
      check("R1 reset status", {30'd0, busy, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // erased location reads all ones
      run_op(1'b0, 4'd0, 8'h00);
      // R7 AND behaviour: 0x81 then 0x03 -> 0x01 with mismatch
      run_op(1'b1, 4'd1, 8'h81);
      run_op(1'b1, 4'd1, 8'h03);
      check("R7 0x03 over 0x81", rdata, 8'h01);
      run_op(1'b0, 4'd1, 8'h00);
      // rewrite of identical byte passes
      run_op(1'b1, 4'd2, 8'h5A);
      run_op(1'b1, 4'd2, 8'h5A);

      // R9: request during busy is ignored
      addr = 4'd5;
      @(negedge clk);
      start = 1'b1; wr = 1'b1; wdata = 8'h0F;
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      start = 1'b1; wr = 1'b1; wdata = 8'h00;
      @(negedge clk);
      start = 1'b0;
      wait_done(rd, f);
      shadow[5] = 8'h0F;
      check("R9 first data kept", rd, 8'h0F);
      check("R9 first verify", f, 1'b0);
      repeat (4) @(negedge clk);
      check("R9 no follow-on cycle", busy, 1'b0);
      run_op(1'b0, 4'd5, 8'h00);

      // random mix on a few addresses
      for (int n = 0; n < 40; n++) begin
         logic [3:0]    a;
         logic [DW-1:0] d;
         logic          w;
         a = 4'($urandom_range(0, 5));
         w = 1'($urandom_range(0, 1));
         case ($urandom_range(0, 3))
            0: d = shadow[a];
            1: d = shadow[a] & 8'($urandom);
            default: d = 8'($urandom);
         endcase
         run_op(w, a, d);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule